// File: doc/BRIEF.md
# Dual-Channel Data-Ready Controller

This block sits between two sampling channels and the host-facing read logic of a two-channel acquisition front end. It decides when a data-ready pulse leaves the device, which channel's samples it announces, and what data the serial shifter sees once a read begins. Each channel presents its current filter output word together with a sample-valid strobe. The strobe rises at the end of that channel's data-ready clock period. A shared data-ready tick paces the settling delay after a channel comes out of reset or shutdown.

A two-bit mode selects between two schemes. In linked operation a single event, timed by the lagging channel, captures both words together as one 48-bit sample. In the other modes the channels run independently and the mode only chooses which channel's events reach the pin. Two status bits let a host poll for fresh data without using the pin. A bit reads 1 after a status read and drops to 0 when its channel's new data is captured. The pin idles either floating, for a wired-AND line with a pull-up, or driven high.

Top module: `drdy_ctrl`

## Requirements
- R1: After reset `dr_status` is 2'b11, `dr_n` is 1, both output words are zero and `dr_oe` equals `cfg_hiz_n`.
- R2: With `cfg_lat_en`=0, a channel that is not off produces a ready event on every cycle its `smp_vld` bit is high, including the first period after it leaves reset or shutdown.
- R3: With `cfg_lat_en`=1, a channel that leaves reset or shutdown has its ready events blocked until 3 `dr_tick` cycles have passed; a strobe that coincides with the third tick is still blocked, and the next strobe produces an event.
- R4: The pin pulse is active low. `dr_n` is 0 and `dr_oe` is 1 for exactly the one clock cycle after the clock edge that samples the event. Otherwise `dr_n` is 1 and `dr_oe` equals `cfg_hiz_n` (0 means floating, 1 means driven high).
- R5: In mode 2'b00 (linked), an event happens only when the strobe of the lagging channel (`lag_sel`: 0 means channel 0, 1 means channel 1) is high. That event captures both channel words at the same edge. A strobe from the leading channel alone captures nothing and gives no pulse.
- R6: In mode 2'b00, while either `ch_off` bit is 1, no pulse is produced and the status bits are not cleared.
- R7: Pin selection by mode: 2'b01 shows only channel 0 events, 2'b10 shows only channel 1 events, and 2'b11 shows the OR of both.
- R8: In modes 2'b01, 2'b10 and 2'b11 the channels are independent. A channel whose `ch_off` bit is 1 produces no events, and the other channel's events and status still work.
- R9: `word0`/`word1` load the captured words only on an `rd_start` that arrives while no read is open. They keep their value until `rd_end` closes the read, even if events or a further `rd_start` arrive in between.
- R10: A `stat_rd` sets both status bits to 1. A channel's ready event clears its bit (bit 0 for channel 0, bit 1 for channel 1), and the event wins over a `stat_rd` in the same cycle.
- R11: In mode 2'b00 the linked event clears both status bits at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 2 | Per-channel sample-valid strobe (bit 0 is channel 0) |
| smp_data0 | input | 24 | Channel 0 filter output word |
| smp_data1 | input | 24 | Channel 1 filter output word |
| ch_off | input | 2 | Per-channel reset or shutdown flag |
| dr_tick | input | 1 | Data-ready clock period tick |
| lag_sel | input | 1 | Index of the lagging channel |
| rd_start | input | 1 | Serial read begins |
| rd_end | input | 1 | Serial read ends |
| stat_rd | input | 1 | Status register is being read |
| cfg_lat_en | input | 1 | Enable the settling delay |
| cfg_hiz_n | input | 1 | Idle pin level: 0 floating, 1 driven high |
| cfg_mode | input | 2 | Data-ready mode |
| dr_n | output | 1 | Data-ready pin value, active low |
| dr_oe | output | 1 | Data-ready pin output enable |
| dr_status | output | 2 | Per-channel status bits |
| word0 | output | 24 | Channel 0 word presented to the shifter |
| word1 | output | 24 | Channel 1 word presented to the shifter |

## Verification
The hardest case to reach is the settling window. Here a channel is already out of shutdown, but its strobes must stay silent until the third tick after release has passed. Hitting that boundary means the tick and strobe must line up on the exact cycle the counter expires. The bench holds the channel off for a full cycle with the delay enabled, releases it, and then issues four tick-plus-strobe periods. It expects silence on the first three and a pulse on the fourth. A second hard case is an event that lands inside an open read: the bench opens a read, changes the word, fires an event and a repeated `rd_start`, and confirms the presented word holds until the read is closed.

// File: rtl/drdy_pkg.sv
package drdy_pkg;
  typedef enum logic [1:0] {
    DRM_LINKED = 2'b00,
    DRM_CH0    = 2'b01,
    DRM_CH1    = 2'b10,
    DRM_BOTH   = 2'b11
  } drdy_mode_e;

  localparam int unsigned NCH = 2;
endpackage

// File: rtl/drdy_settle.sv
module drdy_settle #(
  parameter int unsigned SETTLE = 3,
  localparam int unsigned CW = $clog2(SETTLE + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lat_en,
  input  logic off,
  input  logic tick,
  output logic settled
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (off) begin
      cnt_d = CW'(SETTLE);
    end else if (tick && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CW'(SETTLE);
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign settled = !lat_en || (cnt_q == '0);
endmodule

// File: rtl/drdy_event.sv
module drdy_event
  import drdy_pkg::*;
(
  input  logic [NCH-1:0] vld,
  input  logic [NCH-1:0] off,
  input  logic [NCH-1:0] settled,
  input  logic           lag_sel,
  input  drdy_mode_e     mode,
  output logic [NCH-1:0] ch_evt,
  output logic           pin_evt
);
  logic [NCH-1:0] solo;
  logic           linked;

  assign solo   = vld & ~off & settled;
  assign linked = vld[lag_sel] && (off == '0) && (&settled);

  always_comb begin
    ch_evt  = solo;
    pin_evt = 1'b0;
    case (mode)
      DRM_LINKED: begin
        ch_evt  = {NCH{linked}};
        pin_evt = linked;
      end
      DRM_CH0:  pin_evt = solo[0];
      DRM_CH1:  pin_evt = solo[1];
      DRM_BOTH: pin_evt = |solo;
      default:  pin_evt = 1'b0;
    endcase
  end
endmodule

// File: rtl/drdy_capture.sv
module drdy_capture
  import drdy_pkg::*;
#(
  parameter int unsigned DW = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCH-1:0]          ch_evt,
  input  logic                    stat_rd,
  input  logic                    rd_start,
  input  logic                    rd_end,
  input  logic [NCH-1:0][DW-1:0]  data,
  output logic [NCH-1:0][DW-1:0]  words,
  output logic [NCH-1:0]          status
);
  logic [NCH-1:0][DW-1:0] cap_q, cap_d, words_q, words_d;
  logic [NCH-1:0]         stat_q, stat_d;
  logic                   rd_q, rd_d, load;

  assign load = rd_start && !rd_q;

  always_comb begin
    rd_d = rd_q;
    if (rd_end) begin
      rd_d = 1'b0;
    end else if (rd_start) begin
      rd_d = 1'b1;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_comb begin
      cap_d[c]   = cap_q[c];
      words_d[c] = words_q[c];
      stat_d[c]  = stat_q[c];
      if (ch_evt[c]) begin
        cap_d[c]  = data[c];
        stat_d[c] = 1'b0;
      end else if (stat_rd) begin
        stat_d[c] = 1'b1;
      end
      if (load) begin
        words_d[c] = cap_q[c];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cap_q[c]   <= '0;
        words_q[c] <= '0;
        stat_q[c]  <= 1'b1;
      end else begin
        cap_q[c]   <= cap_d[c];
        words_q[c] <= words_d[c];
        stat_q[c]  <= stat_d[c];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
    end else begin
      rd_q <= rd_d;
    end
  end

  assign words  = words_q;
  assign status = stat_q;
endmodule

// File: rtl/drdy_ctrl.sv
module drdy_ctrl
  import drdy_pkg::*;
#(
  parameter int unsigned DW     = 24,
  parameter int unsigned SETTLE = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    smp_vld,
  input  logic [DW-1:0] smp_data0,
  input  logic [DW-1:0] smp_data1,
  input  logic [1:0]    ch_off,
  input  logic          dr_tick,
  input  logic          lag_sel,
  input  logic          rd_start,
  input  logic          rd_end,
  input  logic          stat_rd,
  input  logic          cfg_lat_en,
  input  logic          cfg_hiz_n,
  input  logic [1:0]    cfg_mode,
  output logic          dr_n,
  output logic          dr_oe,
  output logic [1:0]    dr_status,
  output logic [DW-1:0] word0,
  output logic [DW-1:0] word1
);
  logic [NCH-1:0]         settled;
  logic [NCH-1:0]         ch_evt;
  logic                   pin_evt;
  logic                   pulse_q, pulse_d;
  logic [NCH-1:0][DW-1:0] data_pk, words_pk;

  for (genvar c = 0; c < NCH; c++) begin : g_settle
    drdy_settle #(.SETTLE(SETTLE)) settle_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .lat_en  (cfg_lat_en),
      .off     (ch_off[c]),
      .tick    (dr_tick),
      .settled (settled[c])
    );
  end

  drdy_event event_i (
    .vld     (smp_vld),
    .off     (ch_off),
    .settled (settled),
    .lag_sel (lag_sel),
    .mode    (drdy_mode_e'(cfg_mode)),
    .ch_evt  (ch_evt),
    .pin_evt (pin_evt)
  );

  assign data_pk = {smp_data1, smp_data0};

  drdy_capture #(.DW(DW)) capture_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ch_evt   (ch_evt),
    .stat_rd  (stat_rd),
    .rd_start (rd_start),
    .rd_end   (rd_end),
    .data     (data_pk),
    .words    (words_pk),
    .status   (dr_status)
  );

  assign word0 = words_pk[0];
  assign word1 = words_pk[1];

  assign pulse_d = pin_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= pulse_d;
    end
  end

  assign dr_n  = !pulse_q;
  assign dr_oe = pulse_q || cfg_hiz_n;
endmodule

// File: rtl/drdy_ctrl_chk.sv
module drdy_ctrl_chk #(
  parameter int unsigned DW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    smp_vld,
  input logic [1:0]    ch_off,
  input logic          rd_start,
  input logic          stat_rd,
  input logic [1:0]    cfg_mode,
  input logic          dr_n,
  input logic          dr_oe,
  input logic [1:0]    dr_status,
  input logic [DW-1:0] word0,
  input logic [DW-1:0] word1
);
  // R4: an active pulse is always driven
  a_r4_pulse_driven: assert property (@(posedge clk) disable iff (!rst_n)
    !dr_n |-> dr_oe);

  // R6: linked mode with a channel off yields no pulse
  a_r6_linked_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'b00 && ch_off != 2'b00) |=> dr_n);

  // R9: presented words move only on a read start
  a_r9_words_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_start |=> ($stable(word0) && $stable(word1)));

  // R10: status read with no strobe sets both bits
  a_r10_status_set: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && smp_vld == 2'b00) |=> dr_status == 2'b11);

  // R11: linked pulse comes with both status bits cleared
  a_r11_linked_status: assert property (@(posedge clk) disable iff (!rst_n)
    (!dr_n && $past(cfg_mode) == 2'b00) |-> dr_status == 2'b00);
endmodule

bind drdy_ctrl drdy_ctrl_chk #(.DW(DW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_vld   (smp_vld),
  .ch_off    (ch_off),
  .rd_start  (rd_start),
  .stat_rd   (stat_rd),
  .cfg_mode  (cfg_mode),
  .dr_n      (dr_n),
  .dr_oe     (dr_oe),
  .dr_status (dr_status),
  .word0     (word0),
  .word1     (word1)
);

// File: tb/drdy_ctrl_tb.sv
module drdy_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  smp_vld;
  logic [23:0] smp_data0, smp_data1;
  logic [1:0]  ch_off;
  logic        dr_tick, lag_sel, rd_start, rd_end, stat_rd;
  logic        cfg_lat_en, cfg_hiz_n;
  logic [1:0]  cfg_mode;
  logic        dr_n, dr_oe;
  logic [1:0]  dr_status;
  logic [23:0] word0, word1;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  drdy_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data0(smp_data0),
    .smp_data1(smp_data1), .ch_off(ch_off), .dr_tick(dr_tick), .lag_sel(lag_sel),
    .rd_start(rd_start), .rd_end(rd_end), .stat_rd(stat_rd),
    .cfg_lat_en(cfg_lat_en), .cfg_hiz_n(cfg_hiz_n), .cfg_mode(cfg_mode),
    .dr_n(dr_n), .dr_oe(dr_oe), .dr_status(dr_status), .word0(word0), .word1(word1)
  );

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic period(input logic [1:0] v, output logic p);
    dr_tick = 1'b1; smp_vld = v;
    step();
    p = !dr_n;
    dr_tick = 1'b0; smp_vld = 2'b00;
    step();
  endtask

  task automatic do_stat_rd();
    stat_rd = 1'b1; step(); stat_rd = 1'b0;
  endtask

  task automatic do_read_start();
    rd_start = 1'b1; step(); rd_start = 1'b0;
  endtask

  task automatic do_read_end();
    rd_end = 1'b1; step(); rd_end = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 status", 48'(dr_status), 48'h3);
    chk("R1 dr_n", 48'(dr_n), 48'h1);
    chk("R1 words", {word1, word0}, 48'h0);
    chk("R1 oe driven", 48'(dr_oe), 48'h1);
    cfg_hiz_n = 1'b0; #1;
    chk("R1 oe float", 48'(dr_oe), 48'h0);
  endtask

  task automatic t_lat_off();
    logic p;
    cfg_mode = 2'b11; cfg_lat_en = 1'b0;
    ch_off = 2'b11; step(); ch_off = 2'b00; step();
    period(2'b11, p);
    chk("R2 first period pulses", 48'(p), 48'h1);
  endtask

  task automatic t_lat_on();
    logic p;
    cfg_mode = 2'b01; cfg_lat_en = 1'b1;
    ch_off = 2'b11; step(); ch_off = 2'b00; step();
    for (int i = 0; i < 3; i++) begin
      period(2'b01, p);
      chk("R3 settling blocked", 48'(p), 48'h0);
    end
    period(2'b01, p);
    chk("R3 pulse after settling", 48'(p), 48'h1);
    cfg_lat_en = 1'b0;
  endtask

  task automatic t_pin();
    cfg_mode = 2'b01; cfg_hiz_n = 1'b0;
    chk("R4 idle float", {46'h0, dr_n, dr_oe}, 48'h2);
    dr_tick = 1'b1; smp_vld = 2'b01;
    #1;
    chk("R4 no pulse before edge", 48'(dr_n), 48'h1);
    step();
    dr_tick = 1'b0; smp_vld = 2'b00;
    chk("R4 pulse low driven", {46'h0, dr_n, dr_oe}, 48'h1);
    step();
    chk("R4 one cycle only", {46'h0, dr_n, dr_oe}, 48'h2);
    cfg_hiz_n = 1'b1; #1;
    chk("R4 idle driven high", {46'h0, dr_n, dr_oe}, 48'h3);
  endtask

  task automatic t_linked();
    logic p;
    cfg_mode = 2'b00; lag_sel = 1'b1; ch_off = 2'b00;
    do_stat_rd();
    smp_data0 = 24'h0C0C0C; smp_data1 = 24'h0D0D0D;
    period(2'b01, p);
    chk("R5 leading strobe no pulse", 48'(p), 48'h0);
    chk("R5 leading strobe status", 48'(dr_status), 48'h3);
    smp_data0 = 24'hA1A2A3; smp_data1 = 24'hB1B2B3;
    dr_tick = 1'b1; smp_vld = 2'b10;
    step();
    dr_tick = 1'b0; smp_vld = 2'b00;
    chk("R5 lagging strobe pulses", 48'(!dr_n), 48'h1);
    chk("R11 both status cleared", 48'(dr_status), 48'h0);
    step();
    smp_data0 = 24'h111111; smp_data1 = 24'h222222;
    do_read_start(); do_read_end();
    chk("R5 both captured together", {word1, word0}, {24'hB1B2B3, 24'hA1A2A3});
  endtask

  task automatic t_linked_off();
    logic p;
    cfg_mode = 2'b00; lag_sel = 1'b1; ch_off = 2'b01;
    do_stat_rd();
    period(2'b11, p);
    chk("R6 no pulse with channel off", 48'(p), 48'h0);
    chk("R6 status untouched", 48'(dr_status), 48'h3);
    ch_off = 2'b00;
  endtask

  task automatic t_modes();
    logic p;
    cfg_mode = 2'b01;
    period(2'b10, p); chk("R7 mode01 ignores ch1", 48'(p), 48'h0);
    period(2'b01, p); chk("R7 mode01 shows ch0", 48'(p), 48'h1);
    cfg_mode = 2'b10;
    period(2'b01, p); chk("R7 mode10 ignores ch0", 48'(p), 48'h0);
    period(2'b10, p); chk("R7 mode10 shows ch1", 48'(p), 48'h1);
    cfg_mode = 2'b11;
    period(2'b10, p); chk("R7 mode11 shows ch1", 48'(p), 48'h1);
    period(2'b01, p); chk("R7 mode11 shows ch0", 48'(p), 48'h1);
  endtask

  task automatic t_indep_off();
    logic p;
    cfg_mode = 2'b11; ch_off = 2'b10;
    do_stat_rd();
    period(2'b11, p);
    chk("R8 live channel pulses", 48'(p), 48'h1);
    chk("R8 only live status cleared", 48'(dr_status), 48'h2);
    period(2'b10, p);
    chk("R8 off channel silent", 48'(p), 48'h0);
    ch_off = 2'b00;
  endtask

  task automatic t_read();
    logic p;
    cfg_mode = 2'b11;
    smp_data0 = 24'h123456;
    period(2'b01, p);
    do_read_start();
    chk("R9 word loaded at start", 48'(word0), 48'h123456);
    smp_data0 = 24'h654321;
    period(2'b01, p);
    chk("R9 hold across event", 48'(word0), 48'h123456);
    do_read_start();
    chk("R9 repeat start ignored", 48'(word0), 48'h123456);
    do_read_end();
    do_read_start(); do_read_end();
    chk("R9 next read sees new word", 48'(word0), 48'h654321);
  endtask

  task automatic t_status();
    cfg_mode = 2'b11; ch_off = 2'b00;
    do_stat_rd();
    chk("R10 read sets both", 48'(dr_status), 48'h3);
    stat_rd = 1'b1; dr_tick = 1'b1; smp_vld = 2'b01;
    step();
    stat_rd = 1'b0; dr_tick = 1'b0; smp_vld = 2'b00;
    chk("R10 event beats read", 48'(dr_status), 48'h2);
    step();
  endtask

  initial begin
    rst_n = 1'b0; smp_vld = 2'b00; smp_data0 = '0; smp_data1 = '0;
    ch_off = 2'b00; dr_tick = 1'b0; lag_sel = 1'b0; rd_start = 1'b0;
    rd_end = 1'b0; stat_rd = 1'b0; cfg_lat_en = 1'b0; cfg_hiz_n = 1'b1;
    cfg_mode = 2'b11;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_lat_off();
    t_lat_on();
    t_pin();
    t_linked();
    t_linked_off();
    t_modes();
    t_indep_off();
    t_read();
    t_status();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule